// File: doc/BRIEF.md
# Firmware-to-Debugger Mailbox Register

This block is an 8-bit mailbox that lets code running on the processor hand single bytes to an external debugger. The processor reaches it through its normal I/O register port, which carries an address, a write strobe, a read strobe and data. The debugger reaches it through a separate port. That port shows the stored byte and accepts a one-cycle clear strobe. A pending flag marks that the processor has written a byte the debugger has not yet collected. The processor sees this flag as the top bit of every mailbox read.

The mailbox shares its I/O address with an ordinary 8-bit peripheral register, which is built into the block. The processor is routed to the mailbox only when three conditions all hold:

- the debug-enable fuse input is set;
- the debugger has granted access;
- no lock bit is set.

In every other case the same address reaches the ordinary register, and the mailbox is left untouched. The transport that carries the debugger port off chip is outside this block.

Top module: `dbg_mailbox`

## Requirements
- R1: After a synchronous reset, the stored mailbox byte, the pending flag and the ordinary register are all zero.
- R2: A processor write to the shared address while the mailbox is selected stores the byte and sets the pending flag, both visible one clock later.
- R3: A processor read of the shared address while the mailbox is selected returns the pending flag in bit 7 and stored bits 6:0 in bits 6:0.
- R4: The debugger port presents all 8 stored bits. A debugger clear pulse drops the pending flag one clock later and leaves the stored byte unchanged.
- R5: When a selected processor write and a debugger clear fall in the same clock, the new byte is stored and the pending flag stays set.
- R6: The mailbox is selected exactly when the fuse input is 1, the access-grant input is 1 and the lock vector is zero. Otherwise a write to the shared address loads the ordinary register, and a read returns its 8 bits.
- R7: A write to the shared address while the mailbox is not selected changes neither the stored mailbox byte nor the pending flag.
- R8: Any set lock bit deselects the mailbox, even with the fuse and the grant both at 1.
- R9: Accesses to any other address change neither register, and a read of another address, or any cycle without a read strobe, returns zero.
- R10: A selected processor write leaves the ordinary register unchanged.
- R11: A debugger clear while the flag is already low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | ADDR_W | Processor I/O address |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data (combinational) |
| fuse_dbg_en | input | 1 | Debug-enable fuse state |
| lock_bits | input | LOCK_W | Lock bits; any set bit forces debug off |
| dbg_grant | input | 1 | Debugger has granted mailbox access |
| dbg_data | output | 8 | Stored mailbox byte for the debugger |
| dbg_pending | output | 1 | Pending flag: byte written, not yet collected |
| dbg_clr | input | 1 | Debugger clear pulse for the pending flag |

## Verification
On every cycle, assertions check the following:

- The two write targets are never enabled together.
- A set lock bit always blocks the mailbox.
- Stored values move only on the strobes that own them.
- A write that coincides with a clear keeps the flag set.
- Reads without a strobe, or at a foreign address, return zero.

What the assertions cannot show is the end-to-end routing. That means which register a given fuse, grant and lock combination actually reaches, and that the byte a read returns is the byte written earlier. The bench shows this by sweeping every combination of the enable inputs and every byte value through the shared address.

// File: rtl/dbg_mailbox_pkg.sv
package dbg_mailbox_pkg;

    localparam int DATA_W = 8;

    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic  wr;
        logic  rd;
        byte_t wdata;
    } io_req_t;

    typedef struct packed {
        logic mbx_wr;
        logic mbx_rd;
        logic reg_wr;
        logic reg_rd;
    } io_route_t;

    function automatic byte_t status_view(input logic pend, input byte_t val);
        return {pend, val[DATA_W-2:0]};
    endfunction

endpackage

// File: rtl/mbx_route.sv
module mbx_route #(
    parameter int ADDR_W   = 6,
    parameter int LOCK_W   = 2,
    parameter int MBX_ADDR = 6'h31
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          addr,
    input  dbg_mailbox_pkg::io_req_t   req,
    input  logic                       fuse_en,
    input  logic                       grant,
    input  logic [LOCK_W-1:0]          locks,
    output dbg_mailbox_pkg::io_route_t route
);
    logic hit;
    logic sel;

    assign hit = (addr == ADDR_W'(MBX_ADDR));
    assign sel = fuse_en && grant && (locks == '0);

    always_comb begin
        route.mbx_wr = hit && req.wr && sel;
        route.mbx_rd = hit && req.rd && sel;
        route.reg_wr = hit && req.wr && !sel;
        route.reg_rd = hit && req.rd && !sel;
    end

    // R6
    single_target_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({route.mbx_wr, route.reg_wr}));

    // R8
    lock_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (|locks) |-> !(route.mbx_wr || route.mbx_rd));
endmodule

// File: rtl/mbx_store.sv
module mbx_store
    import dbg_mailbox_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  byte_t wdata,
    input  logic  clr,
    output byte_t val,
    output logic  pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            val  <= '0;
            pend <= 1'b0;
        end else begin
            if (wr) begin
                val  <= wdata;
                pend <= 1'b1;
            end else if (clr) begin
                pend <= 1'b0;
            end
        end
    end

    // R2
    write_sets_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> (pend && val == $past(wdata)));

    // R4
    clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !wr) |=> !pend);

    // R5
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && wr) |=> pend);

    // R7
    hold_value_chk: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(val));
endmodule

// File: rtl/mbx_plain_reg.sv
module mbx_plain_reg
    import dbg_mailbox_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  byte_t wdata,
    output byte_t q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (wr) q <= wdata;
    end

    // R10
    plain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(q));
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
    import dbg_mailbox_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int LOCK_W   = 2,
    parameter int MBX_ADDR = 6'h31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic              fuse_dbg_en,
    input  logic [LOCK_W-1:0] lock_bits,
    input  logic              dbg_grant,
    output logic [7:0]        dbg_data,
    output logic              dbg_pending,
    input  logic              dbg_clr
);
    io_req_t   req;
    io_route_t route;
    byte_t     mbx_val;
    logic      mbx_pend;
    byte_t     plain_q;

    assign req = '{wr: cpu_wr, rd: cpu_rd, wdata: cpu_wdata};

    mbx_route #(.ADDR_W(ADDR_W), .LOCK_W(LOCK_W), .MBX_ADDR(MBX_ADDR)) u_route (
        .clk     (clk),
        .rst     (rst),
        .addr    (cpu_addr),
        .req     (req),
        .fuse_en (fuse_dbg_en),
        .grant   (dbg_grant),
        .locks   (lock_bits),
        .route   (route)
    );

    mbx_store u_store (
        .clk   (clk),
        .rst   (rst),
        .wr    (route.mbx_wr),
        .wdata (req.wdata),
        .clr   (dbg_clr),
        .val   (mbx_val),
        .pend  (mbx_pend)
    );

    mbx_plain_reg u_plain (
        .clk   (clk),
        .rst   (rst),
        .wr    (route.reg_wr),
        .wdata (req.wdata),
        .q     (plain_q)
    );

    always_comb begin
        if (route.mbx_rd)      cpu_rdata = status_view(mbx_pend, mbx_val);
        else if (route.reg_rd) cpu_rdata = plain_q;
        else                   cpu_rdata = '0;
    end

    assign dbg_data    = mbx_val;
    assign dbg_pending = mbx_pend;

    // R9
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_rd || cpu_addr != ADDR_W'(MBX_ADDR)) |-> cpu_rdata == 8'h00);

    // R3
    read_flag_chk: assert property (@(posedge clk) disable iff (rst)
        route.mbx_rd |-> cpu_rdata[7] == dbg_pending);
endmodule

// File: tb/dbg_mailbox_bench.sv
module dbg_mailbox_bench;
    localparam int ADDR_W = 6;
    localparam int LOCK_W = 2;
    localparam logic [5:0] SH = 6'h31;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic fuse_dbg_en = 1'b0, dbg_grant = 1'b0, dbg_clr = 1'b0;
    logic [LOCK_W-1:0] lock_bits = '0;
    logic [7:0] dbg_data;
    logic dbg_pending;

    int checks = 0, fails = 0;
    logic [7:0] m_val = 0, m_plain = 0;
    logic m_pend = 0;

    always #2.5 clk = ~clk;

    dbg_mailbox #(.ADDR_W(ADDR_W), .LOCK_W(LOCK_W), .MBX_ADDR(6'h31)) u_dbg_mailbox (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .fuse_dbg_en(fuse_dbg_en),
        .lock_bits(lock_bits), .dbg_grant(dbg_grant), .dbg_data(dbg_data),
        .dbg_pending(dbg_pending), .dbg_clr(dbg_clr)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic selected();
        return fuse_dbg_en && dbg_grant && (lock_bits == '0);
    endfunction

    task automatic cpu_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        if (a == SH) begin
            if (selected()) begin m_val = d; m_pend = 1'b1; end
            else m_plain = d;
        end
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 d = cpu_rdata;
        cpu_rd = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        dbg_clr = 1'b1;
        m_pend = 1'b0;
        @(negedge clk);
        dbg_clr = 1'b0;
    endtask

    function automatic logic [7:0] mbx_view();
        return {m_pend, m_val[6:0]};
    endfunction

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] keep;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        chk("R1 dbg_data", dbg_data, 8'h00);
        chk("R1 pending", {7'd0, dbg_pending}, 8'h00);
        cpu_read(SH, rd); chk("R1 plain read", rd, 8'h00);
        fuse_dbg_en = 1; dbg_grant = 1;
        cpu_read(SH, rd); chk("R1 mailbox read", rd, 8'h00);

        // R6/R7/R8/R10: sweep every fuse/grant/lock combination
        for (int cfg = 0; cfg < 16; cfg++) begin
            logic [7:0] v;
            logic [7:0] pre_plain;
            logic [7:0] pre_val;
            logic pre_pend;
            logic s;
            pulse_clr();
            fuse_dbg_en = cfg[0]; dbg_grant = cfg[1]; lock_bits = cfg[3:2];
            s = selected();
            v = 8'((cfg * 37 + 5) & 255) | 8'h80;
            pre_plain = m_plain; pre_val = m_val; pre_pend = m_pend;
            cpu_write(SH, v);
            cpu_read(SH, rd);
            if (s) begin
                chk("R6 selected read", rd, mbx_view());
                chk("R2 dbg_data", dbg_data, v);
                chk("R2 pending", {7'd0, dbg_pending}, 8'h01);
            end else begin
                chk(lock_bits != 0 ? "R8 locked read" : "R6 deselected read", rd, v);
                chk("R7 dbg_data held", dbg_data, pre_val);
                chk("R7 pending held", {7'd0, dbg_pending}, {7'd0, pre_pend});
            end
            fuse_dbg_en = 0;
            cpu_read(SH, rd);
            chk(s ? "R10 plain unchanged" : "R6 plain loaded", rd, s ? pre_plain : v);
        end

        // R3: every byte value through the selected path
        fuse_dbg_en = 1; dbg_grant = 1; lock_bits = 0;
        for (int v = 0; v < 256; v++) begin
            cpu_write(SH, 8'(v));
            cpu_read(SH, rd);
            chk("R3 read view", rd, {1'b1, 7'(v)});
            chk("R4 debugger byte", dbg_data, 8'(v));
        end

        // R4: clear drops flag, byte kept
        cpu_write(SH, 8'hA5);
        pulse_clr();
        chk("R4 pending cleared", {7'd0, dbg_pending}, 8'h00);
        chk("R4 byte kept", dbg_data, 8'hA5);
        cpu_read(SH, rd); chk("R4 read bit7 low", rd, 8'h25);

        // R11: clear while already low
        pulse_clr();
        chk("R11 pending stays low", {7'd0, dbg_pending}, 8'h00);
        chk("R11 byte kept", dbg_data, 8'hA5);

        // R5: write and clear in the same cycle
        @(negedge clk);
        cpu_addr = SH; cpu_wdata = 8'h3C; cpu_wr = 1; dbg_clr = 1;
        @(negedge clk);
        cpu_wr = 0; dbg_clr = 0;
        m_val = 8'h3C; m_pend = 1;
        chk("R5 pending kept", {7'd0, dbg_pending}, 8'h01);
        chk("R5 byte stored", dbg_data, 8'h3C);

        // R9: foreign address
        keep = m_plain;
        cpu_write(SH + 6'd1, 8'h77);
        chk("R9 mailbox untouched", dbg_data, 8'h3C);
        cpu_read(SH + 6'd1, rd); chk("R9 foreign read", rd, 8'h00);
        fuse_dbg_en = 0;
        cpu_write(6'h00, 8'h11);
        cpu_read(SH, rd); chk("R9 plain untouched", rd, keep);
        @(negedge clk);
        cpu_addr = SH;
        #1 chk("R9 no strobe reads zero", cpu_rdata, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule